// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers. Each word carries a sign bit at bit 31 (0 for non-negative, 1 for negative), an 8-bit exponent with a bias of 127 in bits 30:23, and a 23-bit fraction in bits 22:0. A normal number has an implicit leading 1 in front of its fraction. A new operation can be issued on every clock cycle by raising the valid input together with the two operands and the subtract flag. The result appears exactly four cycles later, with its own valid strobe.

The work is spread over four registered stages. The first stage unpacks both operands, orders them by magnitude and shifts the smaller significand right to line up the exponents. Three extra bits are kept below the fraction during this shift: guard, round and sticky. The second stage adds or subtracts the aligned significands. The third stage normalizes the sum and detects underflow. The fourth stage rounds to nearest with ties going to even, renormalizes when rounding carries out of the significand, and detects overflow.

Inputs with a zero exponent field are treated as zero. Inputs with an all-ones exponent field are forwarded to the output unchanged. The only rounding mode is round to nearest, ties to even.

Top module: `fp32_add_pipe`

## Requirements
- R1: For normal operands whose result is in range, out_result equals the exact sum a + b rounded to nearest. The word layout is sign at bit 31, 8-bit exponent with bias 127 at bits 30:23, and fraction at bits 22:0.
- R2: When in_sub is 1, the sign of operand b is inverted before the addition, so the result is a − b.
- R3: The smaller operand is aligned with guard, round and sticky bits kept. A result that lies exactly halfway between two representable values rounds to the one with an even fraction LSB. A result above the halfway point rounds away from zero.
- R4: When rounding carries out of the 24-bit significand, the significand is renormalized and the exponent is incremented.
- R5: If the rounded exponent reaches 255, the result is ±infinity (exponent 255, fraction 0) with the sign of the sum, out_ovf is 1 and out_unf is 0.
- R6: If the normalized exponent is 0 or below, the result is flushed to a zero with the sign of the sum (bits 30:0 all zero), out_unf is 1 and out_ovf is 0.
- R7: A sum that is exactly zero, such as two equal magnitudes with opposite effective signs, returns +0 (0x00000000) with both flags 0.
- R8: An operand whose exponent field is 0 is treated as zero, whatever its fraction bits are.
- R9: If operand a has exponent 255, the result is a unchanged. Otherwise, if b has exponent 255, the result is b with its sign inverted when in_sub is 1. In both cases both flags are 0.
- R10: out_valid equals in_valid delayed by exactly four clock cycles. Operations issued on consecutive cycles come out on consecutive cycles, in order.
- R11: While rst is high, on the next cycle out_valid, out_result, out_ovf and out_unf are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| out_valid | output | 1 | Result strobe, four cycles after issue |
| out_result | output | 32 | Rounded result |
| out_ovf | output | 1 | Exponent overflow to infinity |
| out_unf | output | 1 | Result flushed to zero from below the normal range |

## Verification
The bench aims at rounding ties on both an even and an odd fraction LSB. A design that dropped the guard bit, or rounded every tie up, would return a fraction one ULP off. Rounding carries are exercised both into the next exponent and into infinity. A missing renormalization would leave a wrapped all-zero fraction with the old exponent, and a missing post-round overflow check would emit exponent 255 with a garbage fraction or no flag. The remaining cases are:
- full cancellation down to a single ULP and down to zero, where a wrong leading-zero count or a leaked sign shows up at once;
- denormal inputs, which must not add up into a normal number;
- all-ones exponent passthrough, including the sign flip when subtracting;
- a back-to-back stream, which would expose any stage that stalls or mixes up neighbouring operations.

// File: rtl/fp32_add_pkg.sv
package fp32_add_pkg;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int GRS_W     = 3;
endpackage

// File: rtl/fadd_align.sv
module fadd_align
  import fp32_add_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     in_a,
  input  logic [EXP_W+FRAC_W:0]     in_b,
  input  logic                      in_sub,
  output logic                      al_valid,
  output logic [EXP_W-1:0]          al_exp,
  output logic [FRAC_W+GRS_W:0]     al_big,
  output logic [FRAC_W+GRS_W:0]     al_small,
  output logic                      al_sign,
  output logic                      al_esub,
  output logic                      al_spec,
  output logic [EXP_W+FRAC_W:0]     al_spec_word
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + GRS_W;
  localparam int EMAX  = (1 << EXP_W) - 1;

  logic [EXP_W-1:0]  ea, eb, e_big, e_small;
  logic              sa, sb, za, zb, swap;
  logic [W-2:0]      mag_a, mag_b;
  logic [SIG_W-1:0]  sig_a, sig_b, sig_big, sig_small;
  logic [EXT_W-1:0]  small_ext, shifted;
  logic              lost;
  int                d_i;
  logic              spec_n;
  logic [W-1:0]      spec_word_n;

  always_comb begin
    ea    = in_a[W-2:FRAC_W];
    eb    = in_b[W-2:FRAC_W];
    sa    = in_a[W-1];
    sb    = in_b[W-1] ^ in_sub;
    za    = (ea == '0);
    zb    = (eb == '0);
    sig_a = za ? '0 : {1'b1, in_a[FRAC_W-1:0]};
    sig_b = zb ? '0 : {1'b1, in_b[FRAC_W-1:0]};
    mag_a = za ? '0 : in_a[W-2:0];
    mag_b = zb ? '0 : in_b[W-2:0];
    swap  = (mag_b > mag_a);
    e_big     = swap ? (zb ? '0 : eb) : (za ? '0 : ea);
    e_small   = swap ? (za ? '0 : ea) : (zb ? '0 : eb);
    sig_big   = swap ? sig_b : sig_a;
    sig_small = swap ? sig_a : sig_b;
    small_ext = {sig_small, {GRS_W{1'b0}}};
    d_i = int'(e_big) - int'(e_small);
    if (d_i >= EXT_W) begin
      shifted = '0;
      lost    = |small_ext;
    end else begin
      shifted = small_ext >> d_i;
      lost    = |(small_ext & ~({EXT_W{1'b1}} << d_i));
    end
    spec_n      = 1'b0;
    spec_word_n = '0;
    if (int'(ea) == EMAX) begin
      spec_n      = 1'b1;
      spec_word_n = in_a;
    end else if (int'(eb) == EMAX) begin
      spec_n      = 1'b1;
      spec_word_n = {sb, in_b[W-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_valid     <= 1'b0;
      al_exp       <= '0;
      al_big       <= '0;
      al_small     <= '0;
      al_sign      <= 1'b0;
      al_esub      <= 1'b0;
      al_spec      <= 1'b0;
      al_spec_word <= '0;
    end else begin
      al_valid     <= in_valid;
      al_exp       <= e_big;
      al_big       <= {sig_big, {GRS_W{1'b0}}};
      al_small     <= {shifted[EXT_W-1:1], shifted[0] | lost};
      al_sign      <= swap ? sb : sa;
      al_esub      <= sa ^ sb;
      al_spec      <= spec_n;
      al_spec_word <= spec_word_n;
    end
  end

  // R1
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (al_valid && !al_spec) |-> (al_small <= al_big));
endmodule

// File: rtl/fadd_sum.sv
module fadd_sum
  import fp32_add_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      al_valid,
  input  logic [EXP_W-1:0]          al_exp,
  input  logic [FRAC_W+GRS_W:0]     al_big,
  input  logic [FRAC_W+GRS_W:0]     al_small,
  input  logic                      al_sign,
  input  logic                      al_esub,
  input  logic                      al_spec,
  input  logic [EXP_W+FRAC_W:0]     al_spec_word,
  output logic                      sm_valid,
  output logic [EXP_W-1:0]          sm_exp,
  output logic [FRAC_W+GRS_W+1:0]   sm_sum,
  output logic                      sm_sign,
  output logic                      sm_spec,
  output logic [EXP_W+FRAC_W:0]     sm_spec_word
);
  localparam int EXT_W = FRAC_W + 1 + GRS_W;

  logic [EXT_W:0] sum_n;

  always_comb begin
    if (al_esub) sum_n = {1'b0, al_big} - {1'b0, al_small};
    else         sum_n = {1'b0, al_big} + {1'b0, al_small};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sm_valid     <= 1'b0;
      sm_exp       <= '0;
      sm_sum       <= '0;
      sm_sign      <= 1'b0;
      sm_spec      <= 1'b0;
      sm_spec_word <= '0;
    end else begin
      sm_valid     <= al_valid;
      sm_exp       <= al_exp;
      sm_sum       <= sum_n;
      sm_sign      <= al_sign;
      sm_spec      <= al_spec;
      sm_spec_word <= al_spec_word;
    end
  end
endmodule

// File: rtl/fadd_norm.sv
module fadd_norm
  import fp32_add_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sm_valid,
  input  logic [EXP_W-1:0]          sm_exp,
  input  logic [FRAC_W+GRS_W+1:0]   sm_sum,
  input  logic                      sm_sign,
  input  logic                      sm_spec,
  input  logic [EXP_W+FRAC_W:0]     sm_spec_word,
  output logic                      nm_valid,
  output logic [EXP_W:0]            nm_exp,
  output logic [FRAC_W+GRS_W:0]     nm_mant,
  output logic                      nm_sign,
  output logic                      nm_zero,
  output logic                      nm_unf,
  output logic                      nm_spec,
  output logic [EXP_W+FRAC_W:0]     nm_spec_word
);
  localparam int EXT_W = FRAC_W + 1 + GRS_W;

  int               lz_i, e_i;
  logic [EXT_W-1:0] mant_n;
  logic             zero_n, unf_n;

  always_comb begin
    lz_i = EXT_W;
    for (int i = 0; i < EXT_W; i++)
      if (sm_sum[i]) lz_i = EXT_W - 1 - i;
    zero_n = (sm_sum == '0);
    if (sm_sum[EXT_W]) begin
      mant_n = {sm_sum[EXT_W:2], sm_sum[1] | sm_sum[0]};
      e_i    = int'(sm_exp) + 1;
    end else begin
      mant_n = sm_sum[EXT_W-1:0] << lz_i;
      e_i    = int'(sm_exp) - lz_i;
    end
    unf_n = !zero_n && (e_i <= 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nm_valid     <= 1'b0;
      nm_exp       <= '0;
      nm_mant      <= '0;
      nm_sign      <= 1'b0;
      nm_zero      <= 1'b0;
      nm_unf       <= 1'b0;
      nm_spec      <= 1'b0;
      nm_spec_word <= '0;
    end else begin
      nm_valid     <= sm_valid;
      nm_exp       <= unf_n ? '0 : e_i[EXP_W:0];
      nm_mant      <= mant_n;
      nm_sign      <= sm_sign;
      nm_zero      <= zero_n;
      nm_unf       <= unf_n;
      nm_spec      <= sm_spec;
      nm_spec_word <= sm_spec_word;
    end
  end

  // R3
  lead_one_chk: assert property (@(posedge clk) disable iff (rst)
    (nm_valid && !nm_zero && !nm_spec) |-> nm_mant[EXT_W-1]);
endmodule

// File: rtl/fadd_round.sv
module fadd_round
  import fp32_add_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      nm_valid,
  input  logic [EXP_W:0]            nm_exp,
  input  logic [FRAC_W+GRS_W:0]     nm_mant,
  input  logic                      nm_sign,
  input  logic                      nm_zero,
  input  logic                      nm_unf,
  input  logic                      nm_spec,
  input  logic [EXP_W+FRAC_W:0]     nm_spec_word,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     out_result,
  output logic                      out_ovf,
  output logic                      out_unf
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int EMAX  = (1 << EXP_W) - 1;

  logic [SIG_W-1:0]  sig;
  logic              g_bit, r_bit, s_bit, up;
  logic [SIG_W:0]    sig_r;
  logic [EXP_W:0]    exp_r;
  logic [FRAC_W-1:0] frac_r;
  logic [W-1:0]      res_n;
  logic              ovf_n, unf_n;

  always_comb begin
    sig    = nm_mant[FRAC_W+GRS_W:GRS_W];
    g_bit  = nm_mant[2];
    r_bit  = nm_mant[1];
    s_bit  = nm_mant[0];
    up     = g_bit & (r_bit | s_bit | sig[0]);
    sig_r  = {1'b0, sig} + {{SIG_W{1'b0}}, up};
    exp_r  = nm_exp + {{EXP_W{1'b0}}, sig_r[SIG_W]};
    frac_r = sig_r[SIG_W] ? sig_r[SIG_W-1:1] : sig_r[FRAC_W-1:0];
    ovf_n  = 1'b0;
    unf_n  = 1'b0;
    if (nm_spec) begin
      res_n = nm_spec_word;
    end else if (nm_zero) begin
      res_n = '0;
    end else if (nm_unf) begin
      res_n = {nm_sign, {(W-1){1'b0}}};
      unf_n = 1'b1;
    end else if (int'(exp_r) >= EMAX) begin
      res_n = {nm_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_n = 1'b1;
    end else begin
      res_n = {nm_sign, exp_r[EXP_W-1:0], frac_r};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_unf    <= 1'b0;
    end else begin
      out_valid  <= nm_valid;
      out_result <= res_n;
      out_ovf    <= ovf_n;
      out_unf    <= unf_n;
    end
  end

  // R5
  inf_form_chk: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_result[W-2:FRAC_W] == {EXP_W{1'b1}}) && (out_result[FRAC_W-1:0] == '0));

  // R6
  flush_form_chk: assert property (@(posedge clk) disable iff (rst)
    out_unf |-> (out_result[W-2:0] == '0));
endmodule

// File: rtl/fp32_add_pipe.sv
module fp32_add_pipe
  import fp32_add_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] in_a,
  input  logic [EXP_W+FRAC_W:0] in_b,
  input  logic                  in_sub,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_result,
  output logic                  out_ovf,
  output logic                  out_unf
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int EXT_W = FRAC_W + 1 + GRS_W;

  logic             al_valid, al_sign, al_esub, al_spec;
  logic [EXP_W-1:0] al_exp;
  logic [EXT_W-1:0] al_big, al_small;
  logic [W-1:0]     al_spec_word;

  logic             sm_valid, sm_sign, sm_spec;
  logic [EXP_W-1:0] sm_exp;
  logic [EXT_W:0]   sm_sum;
  logic [W-1:0]     sm_spec_word;

  logic             nm_valid, nm_sign, nm_zero, nm_unf, nm_spec;
  logic [EXP_W:0]   nm_exp;
  logic [EXT_W-1:0] nm_mant;
  logic [W-1:0]     nm_spec_word;

  fadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_sub(in_sub), .al_valid(al_valid), .al_exp(al_exp), .al_big(al_big),
    .al_small(al_small), .al_sign(al_sign), .al_esub(al_esub),
    .al_spec(al_spec), .al_spec_word(al_spec_word));

  fadd_sum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sum (
    .clk(clk), .rst(rst), .al_valid(al_valid), .al_exp(al_exp),
    .al_big(al_big), .al_small(al_small), .al_sign(al_sign),
    .al_esub(al_esub), .al_spec(al_spec), .al_spec_word(al_spec_word),
    .sm_valid(sm_valid), .sm_exp(sm_exp), .sm_sum(sm_sum),
    .sm_sign(sm_sign), .sm_spec(sm_spec), .sm_spec_word(sm_spec_word));

  fadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk(clk), .rst(rst), .sm_valid(sm_valid), .sm_exp(sm_exp),
    .sm_sum(sm_sum), .sm_sign(sm_sign), .sm_spec(sm_spec),
    .sm_spec_word(sm_spec_word), .nm_valid(nm_valid), .nm_exp(nm_exp),
    .nm_mant(nm_mant), .nm_sign(nm_sign), .nm_zero(nm_zero),
    .nm_unf(nm_unf), .nm_spec(nm_spec), .nm_spec_word(nm_spec_word));

  fadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .clk(clk), .rst(rst), .nm_valid(nm_valid), .nm_exp(nm_exp),
    .nm_mant(nm_mant), .nm_sign(nm_sign), .nm_zero(nm_zero),
    .nm_unf(nm_unf), .nm_spec(nm_spec), .nm_spec_word(nm_spec_word),
    .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf),
    .out_unf(out_unf));

  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 3'd4)  age <= age + 3'd1;
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_ovf, out_unf}));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_ovf && !out_unf));
endmodule

// File: tb/sim_fp32_add_pipe.sv
`timescale 1ns/1ps
module sim_fp32_add_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_sub = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_ovf, out_unf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fp32_add_pipe u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_sub(in_sub), .out_valid(out_valid), .out_result(out_result),
    .out_ovf(out_ovf), .out_unf(out_unf));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic sub, input logic [31:0] exp_res,
                        input logic exp_ovf, input logic exp_unf);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_a = '0; in_b = '0; in_sub = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " result"}, out_result, exp_res);
    check({tag, " ovf"}, {31'b0, out_ovf}, {31'b0, exp_ovf});
    check({tag, " unf"}, {31'b0, out_unf}, {31'b0, exp_unf});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    // R11: outputs cleared while reset is held
    check("R11 valid", {31'b0, out_valid}, 32'd0);
    check("R11 result", out_result, 32'd0);
    check("R11 flags", {30'b0, out_ovf, out_unf}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_basic;
    run_op("R1 1+1",       32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0);
    run_op("R1 1.5+2.25",  32'h3FC00000, 32'h40100000, 1'b0, 32'h40700000, 1'b0, 1'b0);
    run_op("R1 1+-0.25",   32'h3F800000, 32'hBE800000, 1'b0, 32'h3F400000, 1'b0, 1'b0);
  endtask

  task automatic t_sub;
    run_op("R2 3-1",       32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0);
    run_op("R2 1-(1-ulp)", 32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 1'b0, 1'b0);
  endtask

  task automatic t_round;
    run_op("R3 tie even",  32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    run_op("R3 tie odd",   32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0);
    run_op("R3 above half",32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 1'b0);
  endtask

  task automatic t_carry;
    run_op("R4 carry",     32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0);
  endtask

  task automatic t_ovf;
    run_op("R5 max+max",   32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0);
    run_op("R5 neg",       32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0);
    run_op("R5 round ovf", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0);
  endtask

  task automatic t_unf;
    run_op("R6 neg flush", 32'h00800000, 32'h00C00000, 1'b1, 32'h80000000, 1'b0, 1'b1);
    run_op("R6 pos flush", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1);
  endtask

  task automatic t_zero;
    run_op("R7 5+-5",      32'h40A00000, 32'hC0A00000, 1'b0, 32'h00000000, 1'b0, 1'b0);
    run_op("R7 -5--5",     32'hC0A00000, 32'hC0A00000, 1'b1, 32'h00000000, 1'b0, 1'b0);
  endtask

  task automatic t_denorm;
    run_op("R8 den+1",     32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    run_op("R8 den+den",   32'h00400000, 32'h00400000, 1'b0, 32'h00000000, 1'b0, 1'b0);
  endtask

  task automatic t_special;
    run_op("R9 a inf",     32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0);
    run_op("R9 b inf sub", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0);
    run_op("R9 a nan",     32'h7FC00000, 32'hFF800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0);
  endtask

  task automatic t_stream;
    logic [31:0] sa [5];
    logic [31:0] sb [5];
    logic [31:0] se [5];
    sa[0] = 32'h3F800000; sb[0] = 32'h3F800000; se[0] = 32'h40000000;
    sa[1] = 32'h40400000; sb[1] = 32'h3F800000; se[1] = 32'h40800000;
    sa[2] = 32'h3FC00000; sb[2] = 32'h40100000; se[2] = 32'h40700000;
    sa[3] = 32'h3F800000; sb[3] = 32'hBE800000; se[3] = 32'h3F400000;
    sa[4] = 32'h40A00000; sb[4] = 32'hC0A00000; se[4] = 32'h00000000;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      // R10: nothing emerges before the fourth cycle, then one per cycle
      if (i == 3) check("R10 early", {31'b0, out_valid}, 32'd0);
      if (i >= 4 && i < 9) begin
        check("R10 stream valid", {31'b0, out_valid}, 32'd1);
        check("R10 stream result", out_result, se[i-4]);
      end
      if (i == 9) check("R10 tail", {31'b0, out_valid}, 32'd0);
      if (i < 5) begin
        in_a = sa[i]; in_b = sb[i]; in_sub = 1'b0; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sub();
    t_round();
    t_carry();
    t_ovf();
    t_unf();
    t_zero();
    t_denorm();
    t_special();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule